// File: doc/BRIEF.md
# Serial memory replay sync generator

This block starts a continuous read from a serial memory whose stored contents form a pair of repeating sync waveforms. The memory shares the block's clock as its serial clock and samples `mosi` on each rising edge. When the block is cleared, it drives `csN` low. It then presents a 32-bit read command on `mosi`. The command is shaped so that the data line has a single low-to-high step: the opcode 0x03 is followed by the address 0xFFFFFF. After the command, `csN` stays low and the memory keeps streaming. Its two serial data lines are passed out as the horizontal and vertical sync outputs.

The command needs no bit counter and no address register. A chain of flops fills with ones once `csN` is low. One tap of the chain drives `mosi`. The last tap marks the point where the memory's data becomes valid. The memory is expected to wrap its read address from 0xFFFFFF to zero. The stored pattern therefore starts with the last byte of the array and continues from address zero.

A new read sequence starts in three cases: synchronous reset, an external restart pulse, or a falling edge on the vertical sync output. In each case `csN` is raised for exactly one clock before the command is sent again.

Top module: `spiReplaySync`

## Requirements
- R1: While `rst` is high, `csN` is 1, `mosi` is 0 and both sync outputs are at the idle level 1 (sampled after each clock edge).
- R2: The 32 `mosi` values that the memory samples after `csN` falls form 0x03FFFFFF, MSB first: opcode 0x03 first, then address 0xFFFFFF.
- R3: `csN` goes low on the first clock edge after a clear (reset, restart pulse or vertical fall). It stays low for as long as no new clear occurs.
- R4: `mosi` is 0 after each of the first six clock edges at which `csN` is low, counting the edge that lowers it as the first. It is 1 from the seventh such edge on and stays 1 until the next clear.
- R5: Both sync outputs stay at the idle level 1 through the first 33 edges of the stream, counting the edge that lowers `csN` as the first. From the 34th edge on, `hSync` equals `hData` and `vSync` equals `vData` in the same cycle, without delay.
- R6: A falling edge on `vSync`, with both the previous and the current sample valid, causes `csN` to go high on the next clock edge for exactly one cycle. After that cycle the full command is sent again from its first bit.
- R7: A one-cycle `restartReq` pulse causes `csN` to go high on the next edge for exactly one cycle. After that cycle the full command is sent again from its first bit.
- R8: If `vData` is low on the first valid stream sample, that sample does not restart the sequence, because the preceding sample was not valid. `csN` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the serial clock of the memory |
| rst | input | 1 | Synchronous reset, high active; acts as a restart |
| restartReq | input | 1 | One-cycle request to restart the read |
| hData | input | 1 | Serial data of the memory holding the horizontal pattern |
| vData | input | 1 | Serial data of the memory holding the vertical pattern |
| csN | output | 1 | Memory chip select, low active |
| mosi | output | 1 | Command data to the memory |
| hSync | output | 1 | Horizontal sync output, idle 1 |
| vSync | output | 1 | Vertical sync output, idle 1 |

## Verification
The assertions check several things on every cycle. Each clear raises `csN` for the next cycle. `csN` stays low when there is no clear. `mosi` never falls between clears and is low right after one. Valid data never appears while `mosi` is low. No restart comes from the first valid sample. The exact 32-bit command word, the cycle on which the sync outputs first show data, and the one-cycle chip-select gap before each new command can only be shown by the bench's scenarios. The bench runs these scenarios for a reset, a restart pulse and a vertical falling edge.

// File: rtl/spiReplaySyncPkg.sv
package spiReplaySyncPkg;
  // Length of the read command: opcode plus address.
  localparam int CMD_BITS   = 32;
  // Leading zeros of opcode 0x03; mosi rises after this many stream clocks.
  localparam int LEAD_ZEROS = 6;
  // Number of sync channels carried by the memories.
  localparam int NUM_CH     = 2;
  // Index of the vertical channel, whose falling edge restarts the read.
  localparam int VS_CH      = 1;
  // Level of a sync output while its data is not valid.
  localparam logic SYNC_IDLE = 1'b1;

  typedef struct packed {
    logic clear;  // restart: raise chip select, empty the fill chain
    logic shift;  // stream running: fill the chain by one
  } ctlStrobe_t;
endpackage

// File: rtl/spiReplayCtl.sv
module spiReplayCtl
  import spiReplaySyncPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restartReq,
  input  logic       vFall,
  output ctlStrobe_t ctl,
  output logic       csN
);
  logic clearNow;
  logic csNq;

  assign clearNow = rst | restartReq | vFall;

  // Chip select is high for exactly the cycle after a clear.
  always_ff @(posedge clk) begin
    csNq <= clearNow;
  end

  assign csN       = csNq;
  assign ctl.clear = clearNow;
  assign ctl.shift = ~csNq & ~clearNow;

  // R6
  clearRaisesCs_chk: assert property (@(posedge clk) disable iff (rst)
    (restartReq || vFall) |=> csN);

  // R3
  csStaysLow_chk: assert property (@(posedge clk) disable iff (rst)
    (!csN && !clearNow) |=> !csN);

  // R7
  csHighOneCycle_chk: assert property (@(posedge clk) disable iff (rst)
    (csN && !clearNow) |=> !csN);
endmodule

// File: rtl/spiReplayDp.sv
module spiReplayDp
  import spiReplaySyncPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic [NUM_CH-1:0] syncIn,
  output logic              mosi,
  output logic [NUM_CH-1:0] syncOut,
  output logic              vFall
);
  localparam int FILL_W = CMD_BITS + 1;

  logic [FILL_W-1:0] fill;
  logic              valid;
  logic              validPrev;
  logic              vPrev;

  // Thermometer chain: one tap shapes the command, the last marks valid data.
  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      fill      <= '0;
      validPrev <= 1'b0;
    end else begin
      if (ctl.shift) fill <= {fill[FILL_W-2:0], 1'b1};
      validPrev <= valid;
    end
    vPrev <= syncIn[VS_CH];
  end

  assign mosi  = fill[LEAD_ZEROS-1];
  assign valid = fill[CMD_BITS];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign syncOut[i] = valid ? syncIn[i] : SYNC_IDLE;
  end

  assign vFall = valid & validPrev & vPrev & ~syncIn[VS_CH];

  // R4
  mosiHold_chk: assert property (@(posedge clk) disable iff (rst)
    (mosi && !ctl.clear) |=> mosi);

  // R4
  mosiLowAfterClear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> !mosi);

  // R5
  validAfterCmd_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> mosi);

  // R8
  noEarlyFall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> !vFall);
endmodule

// File: rtl/spiReplaySync.sv
module spiReplaySync
  import spiReplaySyncPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restartReq,
  input  logic hData,
  input  logic vData,
  output logic csN,
  output logic mosi,
  output logic hSync,
  output logic vSync
);
  ctlStrobe_t        ctl;
  logic              vFall;
  logic [NUM_CH-1:0] syncIn;
  logic [NUM_CH-1:0] syncOut;

  assign syncIn = {vData, hData};

  spiReplayCtl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .restartReq (restartReq),
    .vFall      (vFall),
    .ctl        (ctl),
    .csN        (csN)
  );

  spiReplayDp u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .syncIn  (syncIn),
    .mosi    (mosi),
    .syncOut (syncOut),
    .vFall   (vFall)
  );

  assign hSync = syncOut[0];
  assign vSync = syncOut[VS_CH];
endmodule

// File: tb/spiReplaySync_tb.sv
module spiReplaySync_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restartReq = 1'b0;
  logic hData = 1'b0;
  logic vData = 1'b1;
  logic csN, mosi, hSync, vSync;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spiReplaySync u_dut (
    .clk(clk), .rst(rst), .restartReq(restartReq),
    .hData(hData), .vData(vData),
    .csN(csN), .mosi(mosi), .hSync(hSync), .vSync(vSync)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Walks 40 stream cycles; the first negedge follows the edge that lowers csN.
  task automatic runSequence(input string tag, input logic hInv, input logic earlyLow);
    logic [31:0] cmd = '0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      hData = k[0] ^ hInv;
      vData = (earlyLow && k == 34) ? 1'b0 : 1'b1;
      #1;
      chk("R3", {tag, " csN low"}, 32'(csN), 32'd0);
      chk("R4", {tag, " mosi"}, 32'(mosi), 32'(k >= 7));
      if (k <= 32) cmd = {cmd[30:0], mosi};
      chk("R5", {tag, " hSync"}, 32'(hSync), 32'((k >= 34) ? hData : 1'b1));
      chk(earlyLow ? "R8" : "R5", {tag, " vSync"}, 32'(vSync),
          32'((k >= 34) ? vData : 1'b1));
    end
    chk("R2", {tag, " command word"}, cmd, 32'h03FF_FFFF);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "reset csN", 32'(csN), 32'd1);
    chk("R1", "reset mosi", 32'(mosi), 32'd0);
    chk("R1", "reset hSync", 32'(hSync), 32'd1);
    chk("R1", "reset vSync", 32'(vSync), 32'd1);
    rst = 1'b0;
    runSequence("reset", 1'b0, 1'b0);
  endtask

  task automatic testVerticalFall();
    @(negedge clk);
    vData = 1'b0;
    #1;
    chk("R6", "vSync follows fall", 32'(vSync), 32'd0);
    chk("R6", "csN before restart", 32'(csN), 32'd0);
    @(negedge clk);
    vData = 1'b1;
    #1;
    chk("R6", "csN high after fall", 32'(csN), 32'd1);
    chk("R6", "vSync idle after fall", 32'(vSync), 32'd1);
    chk("R6", "mosi low after fall", 32'(mosi), 32'd0);
    runSequence("vfall", 1'b1, 1'b0);
  endtask

  task automatic testRestartPulse();
    @(negedge clk);
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    #1;
    chk("R7", "csN high after request", 32'(csN), 32'd1);
    chk("R7", "hSync idle after request", 32'(hSync), 32'd1);
    runSequence("restart", 1'b0, 1'b0);
  endtask

  task automatic testEarlyLow();
    @(negedge clk);
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    #1;
    chk("R7", "csN high before early test", 32'(csN), 32'd1);
    runSequence("early", 1'b1, 1'b1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testVerticalFall();
        testRestartPulse();
        testEarlyLow();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule